// File: doc/BRIEF.md
# Segmentable Tapped Shift Register

A 64-stage shift register clocked on the rising edge with a single serial data input and four tap points, one at the last stage of each 16-stage section (stages 16, 32, 48 and 64). One mode control selects how the stages are linked. With the control low, the four sections form one continuous 64-stage chain and all four tap outputs are driven. With the control high, the tap output enables drop and the sections split apart. Stage 1 still takes the serial input. Stages 17, 33 and 49 then take the external inputs of the taps at 16, 32 and 48, so the block acts as four independent 16-stage registers.

Each tap is split into a stage-value output, an output-enable flag and, for the first three taps, an external input. A pad wrapper can combine these into a bidirectional pin. The register holds its contents between clock edges. A synchronous clear lets a bench start from a known all-zero state.

Top module: `tap_shift_chain`

## Requirements
- R1: After reset all 64 stages hold 0, so every tap output reads 0.
- R2: On every rising edge stage 1 loads `din`, in both modes. In either mode a `din` bit applied before edge e appears on `tap_q[0]` after edge e+15.
- R3: With `seg_mode` = 0, a `din` bit loaded at edge e appears on `tap_q[i]` (i = 0..3, the stage 16·(i+1)) after edge e+16·(i+1)−1.
- R4: `tap_oe` is combinational from `seg_mode`: all four bits are 1 while `seg_mode` = 0 and all four are 0 while `seg_mode` = 1.
- R5: With `seg_mode` = 1, the first stage of section i+1 (i = 0..2) loads `tap_in[i]` at each edge. That value appears on `tap_q[i+1]` after 15 further edges.
- R6: With `seg_mode` = 0, the values on `tap_in` have no effect on any tap output.
- R7: A rising edge with `clr` = 1 sets all 64 stages to 0, overriding `din`. With `din` held at 0 afterwards, every tap stays 0 for the next 64 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all stages |
| seg_mode | input | 1 | 0 = one 64-stage chain, 1 = four 16-stage sections |
| din | input | 1 | Serial input to stage 1 |
| tap_in | input | 3 | External inputs at taps 16, 32, 48 (bit 0 = tap 16), used in segmented mode |
| tap_q | output | 4 | Contents of stages 16, 32, 48, 64 (bit 0 = stage 16) |
| tap_oe | output | 4 | Tap output enables, one per tap |

## Verification
A bit driven before edge e is due on tap i after edge e+16·(i+1)−1 in serial mode. In segmented mode a bit on `din` or `tap_in[i]` is due on the next tap 15 edges after it is loaded. The output enables follow the mode input in the same cycle, and a clear shows one edge later. The driver stamps each expected bit with the bench cycle count at which it is due and pushes it onto a queue for that tap. The monitor pops an entry only when the cycle counter reaches its stamp and samples on the falling edge, half a period after the register has settled. The clear is checked directly for the 64 edges that follow it.

// File: rtl/tchain_pkg.sv
package tchain_pkg;
  localparam int unsigned DEF_SEG_LEN = 16;
  localparam int unsigned DEF_NUM_SEG = 4;

  typedef enum logic {
    MODE_CHAIN   = 1'b0,
    MODE_SECTION = 1'b1
  } link_mode_e;
endpackage

// File: rtl/tchain_rst_sync.sv
module tchain_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tchain_section.sv
module tchain_section #(
  parameter int unsigned LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           ser_in,
  output logic [LEN-1:0] stages
);
  logic [LEN-1:0] stg_q;
  logic [LEN-1:0] stg_d;
  logic           stg_en;

  // the chain advances on every edge; the enable is kept explicit
  assign stg_en = 1'b1;

  always_comb begin
    if (clr) stg_d = '0;
    else     stg_d = {stg_q[LEN-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stg_q <= '0;
    else if (stg_en) stg_q <= stg_d;
  end

  assign stages = stg_q;
endmodule

// File: rtl/tchain_link_mux.sv
module tchain_link_mux #(
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               din,
  input  logic               seg_mode,
  input  logic [NUM_SEG-2:0] tails,
  input  logic [NUM_SEG-2:0] ext_in,
  output logic [NUM_SEG-1:0] sec_in
);
  import tchain_pkg::*;

  link_mode_e mode;
  assign mode = link_mode_e'(seg_mode);

  assign sec_in[0] = din;

  for (genvar s = 1; s < NUM_SEG; s++) begin : g_link
    always_comb begin
      if (mode == MODE_SECTION) sec_in[s] = ext_in[s-1];
      else                      sec_in[s] = tails[s-1];
    end
  end
endmodule

// File: rtl/tap_shift_chain.sv
module tap_shift_chain #(
  parameter int unsigned SEG_LEN = tchain_pkg::DEF_SEG_LEN,
  parameter int unsigned NUM_SEG = tchain_pkg::DEF_NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               seg_mode,
  input  logic               din,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_q,
  output logic [NUM_SEG-1:0] tap_oe
);
  localparam int unsigned DEPTH = SEG_LEN * NUM_SEG;

  logic               rst_q_n;
  logic [DEPTH-1:0]   stage_q;
  logic [NUM_SEG-1:0] sec_in;
  logic [NUM_SEG-2:0] tails;

  tchain_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  tchain_link_mux #(.NUM_SEG(NUM_SEG)) u_link (
    .din      (din),
    .seg_mode (seg_mode),
    .tails    (tails),
    .ext_in   (tap_in),
    .sec_in   (sec_in)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_sec
    tchain_section #(.LEN(SEG_LEN)) u_sec (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .clr    (clr),
      .ser_in (sec_in[s]),
      .stages (stage_q[s*SEG_LEN +: SEG_LEN])
    );
    assign tap_q[s] = stage_q[(s+1)*SEG_LEN-1];
  end

  for (genvar s = 0; s < NUM_SEG-1; s++) begin : g_tail
    assign tails[s] = stage_q[(s+1)*SEG_LEN-1];
  end

  assign tap_oe = {NUM_SEG{~seg_mode}};
endmodule

// File: rtl/tchain_chk.sv
module tchain_chk #(
  parameter int unsigned SEG_LEN = 16,
  parameter int unsigned NUM_SEG = 4
) (
  input logic                       clk,
  input logic                       rst_ok,
  input logic                       clr,
  input logic                       seg_mode,
  input logic                       din,
  input logic [NUM_SEG-2:0]         tap_in,
  input logic [NUM_SEG-1:0]         tap_q,
  input logic [NUM_SEG-1:0]         tap_oe,
  input logic [SEG_LEN*NUM_SEG-1:0] stages
);
  logic armed;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_ok |-> stages == '0);

  // R2
  stage_one_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (armed && !clr) |=> stages[0] == $past(din));

  // R4
  oe_on_chk: assert property (@(posedge clk) !seg_mode |-> tap_oe == '1);

  // R4
  oe_off_chk: assert property (@(posedge clk) seg_mode |-> tap_oe == '0);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (armed && clr) |=> stages == '0);

  for (genvar s = 0; s < NUM_SEG-1; s++) begin : g_links
    // R3 R6
    serial_link_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (armed && !clr && !seg_mode) |=> stages[(s+1)*SEG_LEN] == $past(tap_q[s]));

    // R5
    seg_link_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (armed && !clr && seg_mode) |=> stages[(s+1)*SEG_LEN] == $past(tap_in[s]));
  end
endmodule

bind tap_shift_chain tchain_chk #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_q_n),
  .clr      (clr),
  .seg_mode (seg_mode),
  .din      (din),
  .tap_in   (tap_in),
  .tap_q    (tap_q),
  .tap_oe   (tap_oe),
  .stages   (stage_q)
);

// File: tb/tb_tap_shift_chain.sv
`timescale 1ns/1ps
module tb_tap_shift_chain;
  localparam int SL = 16;
  localparam int NS = 4;

  typedef struct {
    int   due;
    logic val;
    int   req;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          clr;
  logic          seg_mode;
  logic          din;
  logic [NS-2:0] tap_in;
  logic [NS-1:0] tap_q;
  logic [NS-1:0] tap_oe;

  int   cyc;
  int   n_chk;
  int   n_bad;
  bit   finished;
  exp_t sb [NS][$];

  tap_shift_chain #(.SEG_LEN(SL), .NUM_SEG(NS)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .seg_mode(seg_mode),
    .din(din), .tap_in(tap_in), .tap_q(tap_q), .tap_oe(tap_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, exp_v);
    end
  endtask

  // monitor: pops expected bits when their due cycle is reached
  always @(negedge clk) begin
    for (int t = 0; t < NS; t++) begin
      if (sb[t].size() > 0 && sb[t][0].due == cyc) begin
        exp_t e;
        e = sb[t].pop_front();
        check($sformatf("R%0d tap%0d", e.req, t), {7'd0, tap_q[t]}, {7'd0, e.val});
      end
    end
  end

  // driver: called at a falling edge, applies one beat and records expectations
  task automatic drive_serial(input logic d, input logic [NS-2:0] ti);
    din    = d;
    tap_in = ti;
    for (int t = 0; t < NS; t++) begin
      exp_t e;
      e.due = cyc + SL*(t+1);
      e.val = d;
      e.req = (t == 0) ? 2 : 3; // R2 on tap 0, R3 and R6 further down
      sb[t].push_back(e);
    end
  endtask

  task automatic drive_seg(input logic d, input logic [NS-2:0] ti);
    exp_t e;
    din    = d;
    tap_in = ti;
    e.due = cyc + SL;
    e.val = d;
    e.req = 2;
    sb[0].push_back(e);
    for (int t = 1; t < NS; t++) begin
      e.val = ti[t-1];
      e.req = 5; // R5
      sb[t].push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog cycle=%0d actual=running expected=done", cyc);
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; clr = 1'b0; seg_mode = 1'b0; din = 1'b0; tap_in = '0;
    idle(3);
    @(negedge clk);
    check("R1 taps after reset", {4'd0, tap_q}, 8'h00);
    check("R4 oe in chain mode", {4'd0, tap_oe}, 8'h0F);
    rst_n = 1'b1;
    idle(4);
    check("R1 taps after release", {4'd0, tap_q}, 8'h00);

    // chain mode: walking, alternating and pseudo-random streams; tap_in toggled (R6)
    for (int k = 0; k < 160; k++) begin
      logic d;
      if (k < 40)       d = (k % 9 == 0);
      else if (k < 80)  d = k[0];
      else              d = 1'($urandom_range(0, 1));
      drive_serial(d, 3'($urandom_range(0, 7)));
      @(negedge clk);
    end
    din = 1'b0; tap_in = 3'b111;
    idle(SL*NS + 2);

    // segmented mode: mode applied together with the first beat
    seg_mode = 1'b1;
    #1;
    check("R4 oe in segmented mode", {4'd0, tap_oe}, 8'h00);
    for (int k = 0; k < 96; k++) begin
      drive_seg(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      @(negedge clk);
    end
    tap_in = '0;
    idle(SL + 2);

    // back to chain mode, fill with ones, then clear with din high
    seg_mode = 1'b0;
    #1;
    check("R4 oe back in chain mode", {4'd0, tap_oe}, 8'h0F);
    din = 1'b1;
    idle(SL*NS + 1);
    check("R7 taps full before clear", {4'd0, tap_q}, 8'h0F);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    din = 1'b0;
    check("R7 taps after clear", {4'd0, tap_q}, 8'h00);
    for (int k = 0; k < SL*NS; k++) begin
      @(negedge clk);
      check("R7 no residue after clear", {4'd0, tap_q}, 8'h00);
    end

    for (int t = 0; t < NS; t++)
      if (sb[t].size() != 0) check("R3 scoreboard drained", 8'(sb[t].size()), 8'h00);
    summary();
  end
endmodule